// File: doc/BRIEF.md
# Per-Channel Level/Edge Trigger Matcher

This block watches a sampled input bus, one bit per channel, and raises a one-cycle trigger pulse once every channel chosen by an enable mask satisfies its own condition in the same sample. Three configuration vectors set the condition for each channel. A mode vector chooses between level and edge. A polarity vector chooses low/high in level mode and falling/rising in edge mode. An enable vector sets which channels take part in the decision. The sample most recently accepted can be read back in full.

Software or a capture sequencer arms the matcher with a single-cycle `arm` strobe. Samples arrive with a `smp_valid` qualifier. The matcher registers each sample and keeps the one before it for edge detection. It counts no edge until two samples have been taken since the last arm. After one pulse the matcher goes idle and stays idle until the next arm.

Top module: `trig_match`

## Requirements
- R1: A channel with enable 1, mode 0 and polarity 1 is met when its sampled bit is 1. With polarity 0 it is met when the bit is 0.
- R2: A channel with enable 1 and mode 1 is met on a rise (previous sample bit 0, current 1) when polarity is 1, and on a fall (previous 1, current 0) when polarity is 0. The previous sample is the valid sample accepted just before the current one.
- R3: A channel whose enable bit is 0 has no effect on the trigger, whatever its input, polarity and mode.
- R4: The trigger fires only when all enabled channels are met together on the same sample. One unmet enabled channel blocks it.
- R5: The first valid sample accepted after an arm cannot satisfy an edge-mode channel, even if it differs from the sample held before the arm.
- R6: With the enable vector all zeros, the first valid sample accepted while armed fires the trigger.
- R7: `trig_pulse` is high for exactly the cycle after the clock edge that accepts the qualifying sample (`smp_valid` high at that edge). After reset it is low, and `cur_sample` reads 0.
- R8: Pulses occur only while armed. Reset leaves the matcher disarmed. A pulse disarms it, so no second pulse follows until `arm` is asserted again.
- R9: `cur_sample` shows the data accepted at the most recent edge with `smp_valid` high, from the next cycle on. It holds while `smp_valid` is low.
- R10: A sample presented in the same cycle as `arm` is the first sample of the new armed period. `arm` takes precedence over disarming by a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle strobe that arms the matcher and restarts edge history |
| smp_valid | input | 1 | Qualifies `smp_in` for this cycle |
| smp_in | input | CH_W | Sampled channel values |
| pol_sel | input | CH_W | Per channel: 0 low/falling, 1 high/rising |
| mode_sel | input | CH_W | Per channel: 0 level, 1 edge |
| en_mask | input | CH_W | Per channel: 1 takes part in the trigger decision |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| cur_sample | output | CH_W | Most recently accepted sample |

## Verification
The hardest case to reach is an edge-mode channel whose previous and current samples would form a matching edge, but where an arm falls between the two. The stimulus arms with no sample, then presents a value that, paired with the sample held from before the arm, is exactly the wanted edge. No pulse may follow. Only the next genuine edge after that may fire. A second subtle case is a pulse and a re-arm in back-to-back cycles, including an arm that arrives with its own sample. The vector table chains configurations so that each group starts straight after the pulse of the one before.

// File: rtl/trig_pkg.sv
package trig_pkg;

   typedef enum logic [1:0] {
      COND_LOW  = 2'b00,
      COND_HIGH = 2'b01,
      COND_FALL = 2'b10,
      COND_RISE = 2'b11
   } cond_e;

   // mode bit selects level/edge, polarity bit selects direction
   function automatic cond_e cond_of(input logic mode_b, input logic pol_b);
      return cond_e'({mode_b, pol_b});
   endfunction

   function automatic logic cond_met(input cond_e c, input logic cur_b,
                                     input logic prev_b, input logic hist_ok);
      logic r;
      unique case (c)
         COND_LOW:  r = ~cur_b;
         COND_HIGH: r = cur_b;
         COND_FALL: r = hist_ok & prev_b & ~cur_b;
         default:   r = hist_ok & ~prev_b & cur_b;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/trig_sample_stage.sv
module trig_sample_stage #(
   parameter int CH_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            smp_valid,
   input  logic [CH_W-1:0] smp_in,
   output logic [CH_W-1:0] cur_q,
   output logic [CH_W-1:0] prev_q,
   output logic            new_q,
   output logic            hist_ok_q
);

   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         prev_q    <= '0;
         new_q     <= 1'b0;
         seen_q    <= 1'b0;
         hist_ok_q <= 1'b0;
      end else begin
         new_q <= smp_valid;
         if (smp_valid) begin
            cur_q  <= smp_in;
            prev_q <= cur_q;
         end
         if (arm) begin
            seen_q    <= smp_valid;
            hist_ok_q <= 1'b0;
         end else if (smp_valid) begin
            hist_ok_q <= seen_q;
            seen_q    <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/trig_chan_qual.sv
module trig_chan_qual
   import trig_pkg::*;
#(
   parameter int CH_W = 32
) (
   input  logic [CH_W-1:0] cur_q,
   input  logic [CH_W-1:0] prev_q,
   input  logic            hist_ok,
   input  logic [CH_W-1:0] pol_sel,
   input  logic [CH_W-1:0] mode_sel,
   input  logic [CH_W-1:0] en_mask,
   output logic            all_met
);

   logic [CH_W-1:0] ok_vec;

   for (genvar ch = 0; ch < CH_W; ch++) begin : g_ch
      always_comb begin
         ok_vec[ch] = ~en_mask[ch] |
                      cond_met(cond_of(mode_sel[ch], pol_sel[ch]),
                               cur_q[ch], prev_q[ch], hist_ok);
      end
   end

   assign all_met = &ok_vec;

endmodule

// File: rtl/trig_arm_ctl.sv
module trig_arm_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic fire,
   output logic armed_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (arm)   armed_q <= 1'b1;
      else if (fire)  armed_q <= 1'b0;
   end

endmodule

// File: rtl/trig_match.sv
module trig_match #(
   parameter int CH_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            smp_valid,
   input  logic [CH_W-1:0] smp_in,
   input  logic [CH_W-1:0] pol_sel,
   input  logic [CH_W-1:0] mode_sel,
   input  logic [CH_W-1:0] en_mask,
   output logic            trig_pulse,
   output logic [CH_W-1:0] cur_sample
);

   localparam int MAX_CH = 1024;

   if (CH_W < 1 || CH_W > MAX_CH) begin : g_bad_width
      $error("trig_match: CH_W out of range");
   end

   logic [CH_W-1:0] cur_q, prev_q;
   logic            new_q, hist_ok_q, all_met, armed_q;

   trig_sample_stage #(.CH_W(CH_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .smp_valid (smp_valid),
      .smp_in    (smp_in),
      .cur_q     (cur_q),
      .prev_q    (prev_q),
      .new_q     (new_q),
      .hist_ok_q (hist_ok_q)
   );

   trig_chan_qual #(.CH_W(CH_W)) u_qual (
      .cur_q    (cur_q),
      .prev_q   (prev_q),
      .hist_ok  (hist_ok_q),
      .pol_sel  (pol_sel),
      .mode_sel (mode_sel),
      .en_mask  (en_mask),
      .all_met  (all_met)
   );

   trig_arm_ctl u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .fire    (trig_pulse),
      .armed_q (armed_q)
   );

   assign trig_pulse = armed_q & new_q & all_met;
   assign cur_sample = cur_q;

endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
   parameter int CH_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            arm,
   input logic            smp_valid,
   input logic [CH_W-1:0] smp_in,
   input logic [CH_W-1:0] pol_sel,
   input logic [CH_W-1:0] mode_sel,
   input logic [CH_W-1:0] en_mask,
   input logic            trig_pulse,
   input logic [CH_W-1:0] cur_sample,
   input logic            armed,
   input logic            new_smp,
   input logic            hist_ok
);

   a_r1_level_match: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> (((cur_sample ^ pol_sel) & en_mask & ~mode_sel) == '0));

   a_r5_no_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pulse && !hist_ok) |-> ((mode_sel & en_mask) == '0));

   a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask == '0 && armed && new_smp) |-> trig_pulse);

   a_r7_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(smp_valid));

   a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_pulse && !arm) |=> !trig_pulse);

   a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(smp_valid)) |-> (cur_sample == $past(smp_in)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(smp_valid)) |-> $stable(cur_sample));

endmodule

bind trig_match trig_match_chk #(.CH_W(CH_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .smp_valid  (smp_valid),
   .smp_in     (smp_in),
   .pol_sel    (pol_sel),
   .mode_sel   (mode_sel),
   .en_mask    (en_mask),
   .trig_pulse (trig_pulse),
   .cur_sample (cur_sample),
   .armed      (armed_q),
   .new_smp    (new_q),
   .hist_ok    (hist_ok_q)
);

// File: tb/trig_match_tb.sv
module trig_match_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int NV = 25;
   localparam int VW = 3 + 4*W;

   // {arm, valid, data, pol, mode, mask, expected pulse}
   localparam logic [VW-1:0] VEC [NV] = '{
      // level: bits 7:4 high, 3:0 low (R1, R3, R8, R10)
      {1'b1, 1'b0, 32'h0000_0000, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b0},
      {1'b0, 1'b1, 32'h0000_000F, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b0},
      {1'b0, 1'b1, 32'h0000_00F0, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b1},
      {1'b0, 1'b1, 32'h0000_00F0, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b0},
      {1'b1, 1'b1, 32'h0000_00F1, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b0},
      {1'b0, 1'b1, 32'h0000_0070, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b0},
      {1'b0, 1'b1, 32'hABCD_00F0, 32'h0000_00F0, 32'h0, 32'h0000_00FF, 1'b1},
      // edge: ch0 rising, ch1 falling (R2, R4, R5)
      {1'b1, 1'b1, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h1, 32'h1, 32'h3, 32'h3, 1'b1},
      {1'b1, 1'b1, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b1, 1'b0, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h1, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h2, 32'h1, 32'h3, 32'h3, 1'b0},
      {1'b0, 1'b1, 32'h1, 32'h1, 32'h3, 32'h3, 1'b1},
      // mixed: ch1 level low, ch2 rising, ch0 masked (R3, R4)
      {1'b1, 1'b1, 32'h0, 32'h5, 32'h4, 32'h6, 1'b0},
      {1'b0, 1'b1, 32'h4, 32'h5, 32'h4, 32'h6, 1'b1},
      {1'b1, 1'b1, 32'h0, 32'h5, 32'h4, 32'h6, 1'b0},
      {1'b0, 1'b1, 32'h6, 32'h5, 32'h4, 32'h6, 1'b0},
      {1'b0, 1'b1, 32'h0, 32'h5, 32'h4, 32'h6, 1'b0},
      {1'b0, 1'b1, 32'h5, 32'h5, 32'h4, 32'h6, 1'b1},
      // empty mask (R6, R7)
      {1'b1, 1'b0, 32'h0000_1234, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0},
      {1'b0, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1},
      {1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm = 1'b0;
   logic          smp_valid = 1'b0;
   logic [W-1:0]  smp_in = '0;
   logic [W-1:0]  pol_sel = '0;
   logic [W-1:0]  mode_sel = '0;
   logic [W-1:0]  en_mask = '0;
   logic          trig_pulse;
   logic [W-1:0]  cur_sample;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] exp_cur = '0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_match #(.CH_W(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .smp_valid  (smp_valid),
      .smp_in     (smp_in),
      .pol_sel    (pol_sel),
      .mode_sel   (mode_sel),
      .en_mask    (en_mask),
      .trig_pulse (trig_pulse),
      .cur_sample (cur_sample)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // drive at falling edge, check just after the accepting rising edge
   task automatic step(input logic a, input logic v, input logic [W-1:0] d,
                       input logic exp_p, input string req);
      @(negedge clk);
      arm = a; smp_valid = v; smp_in = d;
      @(posedge clk);
      #1;
      if (v) exp_cur = d;
      check(req, {31'b0, trig_pulse}, {31'b0, exp_p});
      check("R9 readback", cur_sample, exp_cur);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset pulse", {31'b0, trig_pulse}, 32'h0);
      check("R7 reset readback", cur_sample, '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] e;
         e = VEC[i];
         pol_sel  = e[3*W:2*W+1];
         mode_sel = e[2*W:W+1];
         en_mask  = e[W:1];
         step(e[VW-1], e[VW-2], e[4*W:3*W+1], e[0],
              "R1 R2 R3 R4 R5 R6 R10 vector");
      end

      // R8: after reset, never armed, empty mask must not fire
      @(negedge clk);
      rst_n = 1'b0; arm = 1'b0; smp_valid = 1'b0;
      pol_sel = '0; mode_sel = '0; en_mask = '0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      exp_cur = '0;
      step(1'b0, 1'b1, 32'h1111_1111, 1'b0, "R8 unarmed");
      step(1'b0, 1'b1, 32'h2222_2222, 1'b0, "R8 unarmed");
      step(1'b0, 1'b0, 32'h0, 1'b0, "R8 unarmed idle");
      // R10: arm with its own sample, empty mask fires at once
      step(1'b1, 1'b1, 32'h3333_3333, 1'b1, "R10 arm with sample");
      // R7: pulse lasts one cycle, R8: stays disarmed
      step(1'b0, 1'b0, 32'h0, 1'b0, "R7 single cycle");
      step(1'b0, 1'b1, 32'h4444_4444, 1'b0, "R8 disarmed after pulse");

      done = 1'b1;
      finish_run();
   end

endmodule